// File: doc/BRIEF.md
# Masked Chip-Select Address Decoder

This block sits between an internal bus and an external memory controller and decides which of six programmable address windows an access falls in. Each window holds a 16-bit base, a 16-bit mask, an enable flag and a write-lock flag. The upper 16 bits of each access address are compared with the window base, and any bit whose mask bit is 1 is left out of the compare. The result is registered once and sent out as a one-hot select vector, a hit flag, the index of the winning window and an error flag for writes that land in a locked window.

Out of reset, window 0 works as a catch-all select, so a boot device answers at every address. This lasts until software enables window 0 for the first time. After that, window 0 decodes like any other window. When windows overlap, the lower index takes priority. A write that hits a locked window raises the error flag and asserts no select line, so no external cycle starts.

Configuration is written one 32-bit word at a time through a byte-offset write port. Each window uses three words, 12 bytes apart.

Top module: `cs_window_decoder`

## Requirements
- R1: After reset, every base and mask field is 0, every window is disabled and unlocked, window 0 is in catch-all mode, and `cs_o`, `hit_o`, `win_idx_o` and `berr_o` are all 0.
- R2: An enabled window matches when `acc_addr_i[31:16]` equals its base on every bit whose mask bit is 0. A matching access sets `hit_o`, sets the bit of `cs_o` at that window's index, and puts that index on `win_idx_o`.
- R3: A mask bit of 1 makes the corresponding address bit a don't-care, so addresses that differ only in masked bits select the same window.
- R4: A window whose enable bit is 0 never asserts its select, even when the address compares equal.
- R5: Window 0 matches every access until a configuration write sets its enable bit. This catch-all mode ends permanently once that write happens. After that, clearing the enable bit disables window 0 and does not bring catch-all mode back.
- R6: When several windows match, the lowest index wins, and at most one bit of `cs_o` is ever 1.
- R7: An access that matches no window gives `hit_o`=0, `cs_o`=0, `win_idx_o`=0 and `berr_o`=0.
- R8: When the winning window has its lock bit set, a write gives `berr_o`=1, `hit_o`=1, the window index on `win_idx_o`, and `cs_o`=0. A read of the same window decodes normally with `berr_o`=0.
- R9: The configuration byte offset for window n is 12·n plus a slot offset: slot 0 is the base word, with the base in bits 31:16. Slot 4 is the mask word, with the mask in bits 31:16, the lock bit in bit 8 and the enable bit in bit 0. Slot 8 is the timing word and has no effect on decoding. Writes to the timing slot, or to offsets past the last window, leave the decode unchanged.
- R10: Outputs change on the clock edge that samples `acc_valid_i`=1, one register stage after the inputs. An edge that samples `acc_valid_i`=0 drives all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 7 | Configuration byte offset |
| cfg_wdata_i | input | 32 | Configuration write data |
| acc_valid_i | input | 1 | Access present this cycle |
| acc_addr_i | input | 32 | Access address |
| acc_write_i | input | 1 | 1 = write access, 0 = read access |
| cs_o | output | 6 | One-hot chip select, registered |
| hit_o | output | 1 | Some window matched, registered |
| win_idx_o | output | 3 | Index of the winning window, registered |
| berr_o | output | 1 | Write to a locked window, registered |

## Verification
The bench programs windows that overlap in several ways:
- Window 0 in catch-all mode shadowing another window. A design that left window 0 out of the priority chain would assert two selects.
- A fully masked window placed behind a narrower one. A design with the priority reversed would pick the wrong index.
- Window 0 disabled again after its first enable. A design that tied catch-all mode to the live enable bit would bring the catch-all back.
- Reads and writes aimed at a locked window. A design that applied the lock to reads, or still drove the select on a blocked write, would start an external cycle that must not happen.
- Writes to the timing slot and to out-of-range offsets. A design that decoded offsets loosely would corrupt a neighbouring window.

// File: rtl/cs_dec_pkg.sv
package cs_dec_pkg;
  localparam int CMP_W    = 16;
  localparam int DATA_W   = 32;
  localparam int STRIDE   = 12;
  localparam int OFF_BASE = 0;
  localparam int OFF_MASK = 4;
  localparam int EN_BIT   = 0;
  localparam int LOCK_BIT = 8;

  typedef struct packed {
    logic [CMP_W-1:0] base;
    logic [CMP_W-1:0] amask;
    logic             en;
    logic             lock;
  } win_cfg_t;
endpackage

// File: rtl/cs_win_regs.sv
module cs_win_regs
  import cs_dec_pkg::*;
#(
  parameter int NUM_WIN = 6,
  parameter int CFG_AW  = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  output win_cfg_t          cfg_o [NUM_WIN],
  output logic              boot_o
);
  logic [NUM_WIN-1:0] mask_we;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    localparam int BASE_OFF = w * STRIDE + OFF_BASE;
    localparam int MASK_OFF = w * STRIDE + OFF_MASK;
    logic base_we;
    assign base_we    = cfg_we_i && (cfg_addr_i == CFG_AW'(BASE_OFF));
    assign mask_we[w] = cfg_we_i && (cfg_addr_i == CFG_AW'(MASK_OFF));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cfg_o[w] <= '0;
      end else begin
        if (base_we) cfg_o[w].base <= cfg_wdata_i[DATA_W-1 -: CMP_W];
        if (mask_we[w]) begin
          cfg_o[w].amask <= cfg_wdata_i[DATA_W-1 -: CMP_W];
          cfg_o[w].lock  <= cfg_wdata_i[LOCK_BIT];
          cfg_o[w].en    <= cfg_wdata_i[EN_BIT];
        end
      end
    end
  end

  // catch-all mode of window 0 ends on its first enable, sticky until reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            boot_o <= 1'b1;
    else if (mask_we[0] && cfg_wdata_i[EN_BIT]) boot_o <= 1'b0;
  end
endmodule

// File: rtl/cs_win_match.sv
module cs_win_match
  import cs_dec_pkg::*;
#(
  parameter int NUM_WIN = 6
) (
  input  logic [CMP_W-1:0]   addr_hi_i,
  input  win_cfg_t           cfg_i [NUM_WIN],
  input  logic               boot_i,
  output logic [NUM_WIN-1:0] match_o,
  output logic [NUM_WIN-1:0] lock_o
);
  for (genvar w = 0; w < NUM_WIN; w++) begin : g_cmp
    logic eq;
    assign eq        = ((addr_hi_i ^ cfg_i[w].base) & ~cfg_i[w].amask) == '0;
    assign lock_o[w] = cfg_i[w].lock;
    if (w == 0) begin : g_glob
      assign match_o[w] = boot_i || (cfg_i[w].en && eq);
    end else begin : g_norm
      assign match_o[w] = cfg_i[w].en && eq;
    end
  end
endmodule

// File: rtl/cs_prio_pick.sv
module cs_prio_pick #(
  parameter int NUM_WIN = 6,
  localparam int IDX_W  = $clog2(NUM_WIN)
) (
  input  logic [NUM_WIN-1:0] req_i,
  output logic [NUM_WIN-1:0] gnt_o,
  output logic [IDX_W-1:0]   idx_o,
  output logic               any_o
);
  always_comb begin
    logic found;
    found = 1'b0;
    gnt_o = '0;
    idx_o = '0;
    for (int w = 0; w < NUM_WIN; w++) begin
      if (req_i[w] && !found) begin
        found    = 1'b1;
        gnt_o[w] = 1'b1;
        idx_o    = IDX_W'(w);
      end
    end
    any_o = found;
  end
endmodule

// File: rtl/cs_window_decoder.sv
module cs_window_decoder
  import cs_dec_pkg::*;
#(
  parameter int NUM_WIN = 6,
  parameter int ADDR_W  = 32,
  parameter int CFG_AW  = 7,
  localparam int IDX_W  = $clog2(NUM_WIN)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic [CFG_AW-1:0]  cfg_addr_i,
  input  logic [31:0]        cfg_wdata_i,
  input  logic               acc_valid_i,
  input  logic [ADDR_W-1:0]  acc_addr_i,
  input  logic               acc_write_i,
  output logic [NUM_WIN-1:0] cs_o,
  output logic               hit_o,
  output logic [IDX_W-1:0]   win_idx_o,
  output logic               berr_o
);
  win_cfg_t           cfg [NUM_WIN];
  logic               boot;
  logic [NUM_WIN-1:0] match, lock, gnt;
  logic [IDX_W-1:0]   idx;
  logic               any, blocked;

  cs_win_regs #(.NUM_WIN(NUM_WIN), .CFG_AW(CFG_AW)) u_regs (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_addr_i, .cfg_wdata_i,
    .cfg_o(cfg), .boot_o(boot)
  );

  cs_win_match #(.NUM_WIN(NUM_WIN)) u_match (
    .addr_hi_i(acc_addr_i[ADDR_W-1 -: CMP_W]), .cfg_i(cfg), .boot_i(boot),
    .match_o(match), .lock_o(lock)
  );

  cs_prio_pick #(.NUM_WIN(NUM_WIN)) u_pick (
    .req_i(match), .gnt_o(gnt), .idx_o(idx), .any_o(any)
  );

  assign blocked = acc_write_i && |(gnt & lock);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_o <= '0; hit_o <= 1'b0; win_idx_o <= '0; berr_o <= 1'b0;
    end else if (acc_valid_i) begin
      cs_o      <= blocked ? '0 : gnt;
      hit_o     <= any;
      win_idx_o <= idx;
      berr_o    <= blocked;
    end else begin
      cs_o <= '0; hit_o <= 1'b0; win_idx_o <= '0; berr_o <= 1'b0;
    end
  end
endmodule

// File: rtl/cs_dec_checker.sv
module cs_dec_checker #(
  parameter int NUM_WIN = 6,
  parameter int IDX_W   = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               acc_valid_i,
  input logic               acc_write_i,
  input logic [NUM_WIN-1:0] cs_o,
  input logic               hit_o,
  input logic [IDX_W-1:0]   win_idx_o,
  input logic               berr_o
);
  p_onehot_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cs_o));
  p_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_valid_i |=> (cs_o == '0 && !hit_o && !berr_o));
  p_blocked_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    berr_o |-> (cs_o == '0 && hit_o));
  p_read_ok_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && !acc_write_i) |=> !berr_o);
  p_sel_idx_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|cs_o) |-> (hit_o && cs_o[win_idx_o]));
  p_miss_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (cs_o == '0 && !berr_o && win_idx_o == '0));
endmodule

bind cs_window_decoder cs_dec_checker #(.NUM_WIN(NUM_WIN), .IDX_W(IDX_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .acc_valid_i(acc_valid_i),
  .acc_write_i(acc_write_i), .cs_o(cs_o), .hit_o(hit_o),
  .win_idx_o(win_idx_o), .berr_o(berr_o)
);

// File: tb/tb_cs_window_decoder.sv
module tb_cs_window_decoder;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [6:0]  cfg_addr_i = '0;
  logic [31:0] cfg_wdata_i = '0;
  logic        acc_valid_i = 1'b0, acc_write_i = 1'b0;
  logic [31:0] acc_addr_i = '0;
  logic [5:0]  cs_o;
  logic        hit_o, berr_o;
  logic [2:0]  win_idx_o;
  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  cs_window_decoder dut (.*);

  task automatic expect_out(string req, logic [5:0] cs_e, logic hit_e,
                            logic [2:0] idx_e, logic berr_e);
    total++;
    if (cs_o !== cs_e || hit_o !== hit_e || win_idx_o !== idx_e || berr_o !== berr_e) begin
      bad++;
      $display("FAIL %s: cs=%b hit=%b idx=%0d berr=%b expected cs=%b hit=%b idx=%0d berr=%b",
               req, cs_o, hit_o, win_idx_o, berr_o, cs_e, hit_e, idx_e, berr_e);
    end
  endtask

  task automatic wr_cfg(int off, logic [31:0] d);
    cfg_we_i = 1'b1; cfg_addr_i = 7'(off); cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic acc(logic [31:0] a, logic wr);
    acc_valid_i = 1'b1; acc_addr_i = a; acc_write_i = wr;
    @(negedge clk_i);
    acc_valid_i = 1'b0;
  endtask

  task automatic t_reset;
    expect_out("R1 reset outputs", 6'b0, 0, 0, 0);
    acc(32'h1234_5678, 0); expect_out("R5 catch-all read", 6'b000001, 1, 0, 0);
    acc(32'hFFFF_0000, 1); expect_out("R1 R5 catch-all write unlocked", 6'b000001, 1, 0, 0);
  endtask

  task automatic t_basic;
    wr_cfg(12, 32'h6000_0000); wr_cfg(16, 32'h0000_0001);
    acc(32'h6000_1234, 0); expect_out("R5 R6 catch-all shadows win1", 6'b000001, 1, 0, 0);
    wr_cfg(0, 32'h1000_0000); wr_cfg(4, 32'h00FF_0001);
    acc(32'h6000_1234, 0); expect_out("R2 win1 hit", 6'b000010, 1, 1, 0);
    acc(32'h10AB_FFFF, 1); expect_out("R3 masked bits win0", 6'b000001, 1, 0, 0);
    acc(32'h1100_0000, 0); expect_out("R7 miss unmasked bit", 6'b0, 0, 0, 0);
  endtask

  task automatic t_mask_en;
    wr_cfg(24, 32'h8000_0000); wr_cfg(28, 32'h0F00_0001);
    acc(32'h8A00_0000, 0); expect_out("R3 win2 masked nibble", 6'b000100, 1, 2, 0);
    acc(32'h9000_0000, 0); expect_out("R7 win2 outside", 6'b0, 0, 0, 0);
    wr_cfg(36, 32'hA000_0000); wr_cfg(40, 32'h0000_0000);
    acc(32'hA000_0000, 0); expect_out("R4 disabled win3", 6'b0, 0, 0, 0);
  endtask

  task automatic t_lock;
    wr_cfg(60, 32'hC000_0000); wr_cfg(64, 32'h0000_0101);
    acc(32'hC000_0010, 0); expect_out("R8 locked read", 6'b100000, 1, 5, 0);
    acc(32'hC000_0010, 1); expect_out("R8 locked write", 6'b0, 1, 5, 1);
  endtask

  task automatic t_sticky;
    wr_cfg(4, 32'h00FF_0000);
    acc(32'h1000_0000, 0); expect_out("R5 win0 disabled no catch-all", 6'b0, 0, 0, 0);
    acc(32'h6000_0000, 0); expect_out("R5 win1 after win0 off", 6'b000010, 1, 1, 0);
  endtask

  task automatic t_map;
    wr_cfg(20, 32'hFFFF_FFFF);
    acc(32'h6000_0000, 0); expect_out("R9 timing slot ignored", 6'b000010, 1, 1, 0);
    wr_cfg(72, 32'hFFFF_FFFF); wr_cfg(76, 32'hFFFF_FFFF);
    acc(32'h1234_0000, 0); expect_out("R9 out-of-range ignored", 6'b0, 0, 0, 0);
  endtask

  task automatic t_prio;
    wr_cfg(48, 32'h0000_0000); wr_cfg(52, 32'hFFFF_0001);
    acc(32'h8A00_0000, 0); expect_out("R6 win2 beats catch-all win4", 6'b000100, 1, 2, 0);
    acc(32'h7777_0000, 1); expect_out("R6 win4 alone", 6'b010000, 1, 4, 0);
    acc(32'hC000_0000, 1); expect_out("R6 R8 win4 beaten by locked win5? no, win4 lower", 6'b010000, 1, 4, 0);
  endtask

  task automatic t_idle;
    acc(32'h6000_0000, 0);
    @(negedge clk_i);
    expect_out("R10 idle clears outputs", 6'b0, 0, 0, 0);
    acc_valid_i = 1'b1; acc_addr_i = 32'h6000_0000; acc_write_i = 1'b0;
    #1;
    expect_out("R10 no output before edge", 6'b0, 0, 0, 0);
    @(negedge clk_i); acc_valid_i = 1'b0;
    expect_out("R10 output after one edge", 6'b000010, 1, 1, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset; t_basic; t_mask_en; t_lock; t_sticky; t_map; t_prio; t_idle;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule